// File: doc/BRIEF.md
# Zero-Overhead Block Repeat Controller

This unit lets an in-order pipelined core run a block of instructions many times without any branch instructions. A repeat command carries several fields: the address of the repeat instruction, the block length, a count or count source, and the variant. The unit stores three values: the loop top, the loop bottom and the number of passes still to run. From then on it compares the fetch program counter with the bottom address. Each time fetch reaches the bottom and more passes remain, the unit sends fetch back to the top in that same cycle. On the last pass it lets fetch continue to the next address.

There are two issue variants, and they take effect at different pipeline depths. The early variant acts one stage after fetch, so one spacer slot lies between the repeat instruction and the loop top. It always executes and takes a wide immediate count. The late variant acts three stages after fetch, so three spacer slots lie between the repeat instruction and the loop top. It obeys its condition and takes its count from one of three sources: a narrow immediate, a register value, or an unbounded mode. A new command replaces any loop that is running. Loops do not nest.

Top module: `blk_repeat_unit`

## Requirements
- R1: `len_m1` is a 6-bit field that holds the block length minus one, so a block has 1 to 64 instructions. The body then covers `len_m1+1` consecutive addresses.
- R2: When `cmd_late`=0 (early variant), the pass count is `cmd_imm`+1, which gives 1 to 65536 passes from the 16-bit field. The command is accepted whatever the value of `cmd_cond`.
- R3: When `cmd_late`=1 and `cmd_src`=2'b00, the pass count is `cmd_imm[8:0]`+1, which gives 1 to 512 passes. Bits 15:9 of `cmd_imm` have no effect.
- R4: When `cmd_late`=1 and `cmd_src`=2'b01, the pass count is `cmd_reg`+1.
- R5: When `cmd_late`=1 and `cmd_src` is 2'b10 or 2'b11, the loop never ends. Every arrival at the bottom is redirected and `busy` stays high until a new command or a reset arrives.
- R6: A late command with `cmd_cond`=0 is ignored. An idle unit stays idle, and the block then runs once by falling through.
- R7: The loop top is `cmd_pc`+2 for the early variant and `cmd_pc`+4 for the late variant. `redir_pc` always equals that top.
- R8: `redir_valid` is asserted in the same cycle in which `fetch_pc` equals the bottom address and more than one pass remains, or the loop is unbounded. On the final pass there is no redirect and `busy` drops after that clock edge.
- R9: A command accepted while `busy` is high replaces the whole loop state. The old bottom address no longer causes a redirect.
- R10: A synchronous `rst` clears `busy`, and no redirect occurs until a new command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Repeat command present this cycle |
| cmd_late | input | 1 | 0 = early variant, 1 = late variant |
| cmd_cond | input | 1 | Condition result; used by the late variant only |
| cmd_src | input | 2 | Count source for the late variant: 00 immediate, 01 register, 1x unbounded |
| cmd_pc | input | PC_W | Address of the repeat instruction |
| cmd_len_m1 | input | LEN_W | Block length minus one |
| cmd_imm | input | ECNT_W | Immediate count minus one |
| cmd_reg | input | REG_W | Register value D (D+1 passes) |
| fetch_pc | input | PC_W | Current fetch address |
| redir_valid | output | 1 | Send fetch to `redir_pc` this cycle |
| redir_pc | output | PC_W | Loop top address |
| busy | output | 1 | A loop is active |

## Verification
The bench builds the unit with its default widths: a 16-bit PC, a 6-bit length field, a 16-bit early count, a 9-bit late count and a 16-bit register count. It sweeps block lengths 1 to 6 against pass counts 1 to 4 for the early variant, the late immediate source and the late register source. In each case it counts the body executions and compares them with passes times length. Because the early count field is only 16 bits wide, the bench can reach its 65536-pass limit, and it also runs the 512-pass late limit, the largest 64-instruction block, the ignored upper count bits and the unbounded mode. A few longer runs cover replacement of a running loop and reset in the middle of a loop.

// File: rtl/blk_repeat_unit.sv
module blk_repeat_unit #(
  parameter int PC_W   = 16,
  parameter int LEN_W  = 6,
  parameter int ECNT_W = 16,
  parameter int LCNT_W = 9,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_late,
  input  logic              cmd_cond,
  input  logic [1:0]        cmd_src,
  input  logic [PC_W-1:0]   cmd_pc,
  input  logic [LEN_W-1:0]  cmd_len_m1,
  input  logic [ECNT_W-1:0] cmd_imm,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc,
  output logic              busy
);
  localparam int CNT_W     = ((REG_W > ECNT_W) ? REG_W : ECNT_W) + 1;
  localparam int EARLY_GAP = 1;
  localparam int LATE_GAP  = 3;

  logic [PC_W-1:0]  top_q, bot_q;
  logic [CNT_W-1:0] rem_q;
  logic             inf_q, busy_q;

  logic             take, at_bot, more;
  logic [PC_W-1:0]  new_top;
  logic [CNT_W-1:0] new_cnt;
  logic             new_inf;

  assign take    = cmd_valid && (!cmd_late || cmd_cond);
  assign new_top = cmd_pc + PC_W'(1 + (cmd_late ? LATE_GAP : EARLY_GAP));
  assign new_inf = cmd_late && cmd_src[1];

  always_comb begin
    if (!cmd_late)
      new_cnt = CNT_W'(cmd_imm) + CNT_W'(1);
    else if (cmd_src == 2'b01)
      new_cnt = CNT_W'(cmd_reg) + CNT_W'(1);
    else
      new_cnt = CNT_W'(cmd_imm[LCNT_W-1:0]) + CNT_W'(1);
  end

  assign at_bot      = busy_q && (fetch_pc == bot_q);
  assign more        = inf_q || (rem_q > CNT_W'(1));
  assign redir_valid = at_bot && more;
  assign redir_pc    = top_q;
  assign busy        = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      inf_q  <= 1'b0;
      top_q  <= '0;
      bot_q  <= '0;
      rem_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      inf_q  <= new_inf;
      top_q  <= new_top;
      bot_q  <= new_top + PC_W'(cmd_len_m1);
      rem_q  <= new_cnt;
    end else if (at_bot) begin
      if (more) begin
        if (!inf_q) rem_q <= rem_q - CNT_W'(1);
      end else begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk_repeat_chk.sv
module blk_repeat_chk #(
  parameter int PC_W   = 16,
  parameter int LEN_W  = 6,
  parameter int ECNT_W = 16,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_late,
  input logic              cmd_cond,
  input logic [1:0]        cmd_src,
  input logic [PC_W-1:0]   cmd_pc,
  input logic [LEN_W-1:0]  cmd_len_m1,
  input logic [ECNT_W-1:0] cmd_imm,
  input logic [REG_W-1:0]  cmd_reg,
  input logic [PC_W-1:0]   fetch_pc,
  input logic              redir_valid,
  input logic [PC_W-1:0]   redir_pc,
  input logic              busy
);
  assert_redir_needs_busy_R8: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> busy);

  assert_redir_keeps_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && !cmd_valid) |=> busy);

  assert_redir_backward_R7: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (redir_pc <= fetch_pc));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> !busy);

  assert_early_accepted_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_late) |=> busy);

  assert_late_accepted_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_late && cmd_cond) |=> busy);

  assert_late_false_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_late && !cmd_cond && !busy) |=> !busy);

  assert_unbounded_redirects_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_late && cmd_cond && cmd_src[1]) |=> busy);
endmodule

bind blk_repeat_unit blk_repeat_chk #(
  .PC_W(PC_W), .LEN_W(LEN_W), .ECNT_W(ECNT_W), .REG_W(REG_W)
) u_chk (.*);

// File: tb/tb_blk_repeat_unit.sv
module tb_blk_repeat_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_late = 1'b0, cmd_cond = 1'b1;
  logic [1:0]  cmd_src = 2'b00;
  logic [15:0] cmd_pc = '0;
  logic [5:0]  cmd_len_m1 = '0;
  logic [15:0] cmd_imm = '0;
  logic [15:0] cmd_reg = '0;
  logic [15:0] fetch_pc = '0;
  logic        redir_valid, busy;
  logic [15:0] redir_pc;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  blk_repeat_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_late(cmd_late),
    .cmd_cond(cmd_cond), .cmd_src(cmd_src), .cmd_pc(cmd_pc),
    .cmd_len_m1(cmd_len_m1), .cmd_imm(cmd_imm), .cmd_reg(cmd_reg),
    .fetch_pc(fetch_pc), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit late, input bit cond, input logic [1:0] src,
                       input int len, input int imm, input int regv, input int pc0);
    @(negedge clk);
    cmd_late = late; cmd_cond = cond; cmd_src = src;
    cmd_len_m1 = 6'(len - 1); cmd_imm = 16'(imm); cmd_reg = 16'(regv);
    cmd_pc = 16'(pc0); fetch_pc = 16'(pc0); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run(input bit late, input bit cond, input logic [1:0] src,
                     input int len, input int imm, input int regv, input int pc0,
                     input int passes, input string req);
    int top, bot, pc, execs, badtgt, guard;
    top = pc0 + 1 + (late ? 3 : 1);
    bot = top + len - 1;
    execs = 0; badtgt = 0; guard = 0;
    issue(late, cond, src, len, imm, regv, pc0);
    pc = pc0 + 1;
    while (pc <= bot + 1 && guard < 140000) begin
      fetch_pc = 16'(pc);
      #1;
      if (pc >= top && pc <= bot) execs++;
      if (redir_valid) begin
        if (int'(redir_pc) != top) badtgt++;
        pc = int'(redir_pc);
      end else pc++;
      guard++;
      @(negedge clk);
    end
    chk(execs == passes * len, {req, " body executions"}, execs, passes * len);
    chk(badtgt == 0, "R7 redirect target", badtgt, 0);
    chk(busy == 1'b0, "R8 busy after final pass", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int top, reds;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    chk(redir_valid == 1'b0, "R10 reset redirect", int'(redir_valid), 0);
    rst = 1'b0;

    // R1 R2 R3 R4 sweep: length 1..6, passes 1..4
    for (int len = 1; len <= 6; len++)
      for (int c = 1; c <= 4; c++) begin
        run(1'b0, 1'b1, 2'b00, len, c - 1, 0, 100, c, "R2 early");
        run(1'b1, 1'b1, 2'b00, len, c - 1, 0, 200, c, "R3 late imm");
        run(1'b1, 1'b1, 2'b01, len, 0, c - 1, 300, c, "R4 late reg");
      end

    // 4-instruction block, four passes: 16 executions each
    run(1'b0, 1'b1, 2'b00, 4, 3, 0, 1000, 4, "R2 early 4x4");
    run(1'b1, 1'b1, 2'b00, 4, 3, 0, 1100, 4, "R3 late 4x4");
    run(1'b1, 1'b1, 2'b01, 4, 0, 3, 1200, 4, "R4 reg 4x4");

    // R1 largest block
    run(1'b0, 1'b1, 2'b00, 64, 1, 0, 2000, 2, "R1 early 64");
    run(1'b1, 1'b1, 2'b01, 64, 0, 1, 2200, 2, "R1 late 64");

    // R2 condition ignored; R6 late with false condition ignored
    run(1'b0, 1'b0, 2'b00, 3, 2, 0, 2400, 3, "R2 cond ignored");
    run(1'b1, 1'b0, 2'b00, 3, 2, 0, 2500, 1, "R6 late suppressed");
    run(1'b1, 1'b0, 2'b01, 2, 0, 5, 2600, 1, "R6 late reg suppressed");

    // R3 upper immediate bits ignored, and the 512-pass limit
    run(1'b1, 1'b1, 2'b00, 2, 16'hFE01, 0, 2700, 2, "R3 upper bits");
    run(1'b1, 1'b1, 2'b00, 1, 16'h01FF, 0, 2800, 512, "R3 max 512");

    // R2 count limit 65536
    run(1'b0, 1'b1, 2'b00, 1, 16'hFFFF, 0, 3000, 65536, "R2 max 65536");

    // R5 unbounded loop, then R9 replacement
    issue(1'b1, 1'b1, 2'b10, 3, 0, 0, 400);
    top = 404; reds = 0;
    for (int i = 0; i < 150; i++) begin
      fetch_pc = 16'(top + (i % 3));
      #1;
      if (redir_valid) reds++;
      @(negedge clk);
    end
    chk(reds == 50, "R5 unbounded redirects", reds, 50);
    chk(busy == 1'b1, "R5 unbounded busy", int'(busy), 1);
    run(1'b0, 1'b1, 2'b00, 2, 2, 0, 500, 3, "R9 replace");
    fetch_pc = 16'd406;
    #1;
    chk(redir_valid == 1'b0, "R9 old bottom inert", int'(redir_valid), 0);

    // R9 replace a bounded loop midway
    issue(1'b0, 1'b1, 2'b00, 4, 9, 0, 600);
    fetch_pc = 16'd602;
    @(negedge clk);
    run(1'b1, 1'b1, 2'b01, 2, 0, 1, 700, 2, "R9 replace bounded");
    fetch_pc = 16'd605;
    #1;
    chk(redir_valid == 1'b0, "R9 old loop gone", int'(redir_valid), 0);

    // R10 reset in the middle of a loop
    issue(1'b0, 1'b1, 2'b00, 2, 7, 0, 800);
    fetch_pc = 16'd803;
    #1;
    chk(redir_valid == 1'b1, "R8 redirect at bottom", int'(redir_valid), 1);
    chk(int'(redir_pc) == 802, "R7 early top", int'(redir_pc), 802);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fetch_pc = 16'd803;
    #1;
    chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    chk(redir_valid == 1'b0, "R10 no redirect after reset", int'(redir_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule